// File: doc/BRIEF.md
# Serial Flash Page Command Sequencer

This block sits on the host side of a serial page-organised flash memory. It issues the commands that write the contents of one of the device's two on-chip buffers into a main-memory page, and the commands that erase a single page or a group of eight pages. A request carries a command kind, a buffer choice and a page number. The sequencer builds a 32-bit frame from an 8-bit opcode and a 24-bit address field. It shifts the frame out over a mode-0 SPI link with chip select held low. It then raises chip select, which starts the device's self-timed operation.

After chip select rises, the sequencer waits half an SCK period so the device can assert busy. It then watches the ready/busy line. When the line reads ready, it raises a one-cycle done pulse. If busy lasts longer than a limit the host programs, it raises a timeout pulse instead. Page numbers beyond the array, which has 8192 pages, are refused before any bus activity. The SCK rate is set per request by a half-period divider.

Top module: `flash_cmd_seq`

## Requirements
- R1: The first byte of a frame is the opcode. The request kind is encoded on `req_cmd`: 0 = program with erase, 1 = program into an erased page, 2 = page erase, 3 = block erase. The opcodes are: kind 0 gives 0x83 for buffer one (`req_buf`=0) and 0x86 for buffer two (`req_buf`=1); kind 1 gives 0x88 and 0x89; kind 2 gives 0x81; kind 3 gives 0x50. The buffer choice is ignored for kinds 2 and 3.
- R2: For kinds 0 to 2, the 24-bit address field has a 0 in bit 23, the 13-bit page number in bits 22 down to 10, and 0 in bits 9 down to 0.
- R3: For block erase, bits 22 down to 13 of the address field carry page bits 12 down to 3. Every other address bit is 0, so the three low page bits are discarded.
- R4: Each frame has exactly 32 SCK rising edges. Bits go out most significant first. SCK is low whenever chip select is high. SDO holds steady while SCK is high.
- R5: `spi_cs_n` falls at least one clock before the first SCK rise. It stays low for the whole frame and rises only while SCK is low, after the last falling edge.
- R6: Every SCK high phase lasts `div_half`+1 clocks, using the `div_half` value captured when the request is accepted.
- R7: A request with `req_page` greater than 8191 produces a one-cycle `err_range` pulse and no frame. Chip select stays high.
- R8: After chip select rises and a settling time of one half SCK period has passed, `done` pulses for one cycle. The pulse starts on the clock after the first rising edge that samples `flash_rdy` high.
- R9: `req_ready` is low from the moment a request is accepted until done or timeout. Requests made during that time are ignored.
- R10: If `flash_rdy` is still low after `busy_limit` busy clocks following the settling time, `err_timeout` pulses for one cycle, no done follows, and the block returns to idle.
- R11: After reset, `spi_cs_n`=1, `spi_sck`=0, `spi_sdo`=0, `req_ready`=1, and `done`, `err_range` and `err_timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_cmd | input | 2 | Command kind (see R1) |
| req_buf | input | 1 | Buffer choice: 0 first, 1 second |
| req_page | input | 14 | Page number; values above 8191 are refused |
| div_half | input | 8 | SCK half period minus one, in clocks |
| busy_limit | input | 20 | Busy clocks allowed before timeout |
| req_ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err_range | output | 1 | One-cycle pulse for a refused page number |
| err_timeout | output | 1 | One-cycle pulse when busy lasts too long |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sdo | output | 1 | Serial data to the device |
| flash_rdy | input | 1 | Device ready (1) or busy (0) |

## Verification
The bench aims at the opcode table, including the buffer choice that must be ignored for erases. A swapped entry there would send the wrong command byte. It checks block-erase packing with a page whose low three bits are set; a design that reused page packing would leak those bits into the address. It also checks page 8191 against page 8192. An off-by-one range check would either refuse the last page or start a frame for a page that does not exist. It measures the exact clock on which done appears relative to the ready release, and the window in which the timeout fires. A design that sampled ready before the device could assert busy would finish at once. A design that counted the wrong way would time out early or never.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int OPC_W      = 8;
    localparam int ADDR_W     = 24;
    localparam int FRAME_W    = OPC_W + ADDR_W;
    localparam int PAGE_W     = 13;
    localparam int PAGE_COUNT = 1 << PAGE_W;
    localparam int TAIL_W     = ADDR_W - 1 - PAGE_W;
    localparam int GROUP_LSB  = 3;

    typedef enum logic [1:0] {
        CMD_PROG_ERASE  = 2'd0,
        CMD_PROG_PLAIN  = 2'd1,
        CMD_PAGE_ERASE  = 2'd2,
        CMD_BLOCK_ERASE = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_WAIT
    } state_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    function automatic logic [OPC_W-1:0] pick_opcode(cmd_e kind, logic second_buf);
        logic [OPC_W-1:0] op;
        case (kind)
            CMD_PROG_ERASE:  op = second_buf ? 8'h86 : 8'h83;
            CMD_PROG_PLAIN:  op = second_buf ? 8'h89 : 8'h88;
            CMD_PAGE_ERASE:  op = 8'h81;
            default:         op = 8'h50;
        endcase
        return op;
    endfunction

    function automatic logic [ADDR_W-1:0] pack_addr(cmd_e kind, logic [PAGE_W-1:0] page);
        logic [PAGE_W-1:0] p;
        p = page;
        if (kind == CMD_BLOCK_ERASE) begin
            p[GROUP_LSB-1:0] = '0;
        end
        return {1'b0, p, {TAIL_W{1'b0}}};
    endfunction

endpackage

// File: rtl/sck_pacer.sv
module sck_pacer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= half);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FRAME_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    output logic               sdo,
    output logic               last
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr  <= '0;
            cnt <= '0;
        end else if (load) begin
            sr  <= frame_in;
            cnt <= '0;
        end else if (shift) begin
            sr  <= {sr[FRAME_W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    assign sdo  = sr[FRAME_W-1];
    assign last = (cnt == CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/busy_watch.sv
module busy_watch #(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             tick,
    input  logic             rdy,
    input  logic [TMO_W-1:0] limit,
    output logic             finish,
    output logic             expired
);
    logic             settled;
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            settled <= 1'b0;
            cnt     <= '0;
        end else if (!settled) begin
            if (tick) begin
                settled <= 1'b1;
            end
        end else if (!rdy) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign finish  = active && settled && rdy;
    assign expired = active && settled && !rdy && (cnt >= limit);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int TMO_W  = 20,
    parameter int PIN_W  = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_cmd,
    input  logic             req_buf,
    input  logic [PIN_W-1:0] req_page,
    input  logic [DIV_W-1:0] div_half,
    input  logic [TMO_W-1:0] busy_limit,
    output logic             req_ready,
    output logic             done,
    output logic             err_range,
    output logic             err_timeout,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic             spi_sdo,
    input  logic             flash_rdy
);
    state_e           state;
    logic [DIV_W-1:0] div_q;
    logic             tick;
    logic             sh_sdo;
    logic             sh_last;
    logic             in_range;
    logic             load_go;
    logic             shift_go;
    logic             wait_finish;
    logic             wait_expired;
    frame_t           frame;

    assign in_range = (req_page < PIN_W'(PAGE_COUNT));
    assign load_go  = (state == ST_IDLE) && req_valid && in_range;
    assign shift_go = (state == ST_SHIFT) && tick && spi_sck;

    always_comb begin
        frame.opcode = pick_opcode(cmd_e'(req_cmd), req_buf);
        frame.addr   = pack_addr(cmd_e'(req_cmd), req_page[PAGE_W-1:0]);
    end

    sck_pacer #(.DIV_W(DIV_W)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .half (div_q),
        .tick (tick)
    );

    frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load_go),
        .frame_in (frame),
        .shift    (shift_go),
        .sdo      (sh_sdo),
        .last     (sh_last)
    );

    busy_watch #(.TMO_W(TMO_W)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .active  (state == ST_WAIT),
        .tick    (tick),
        .rdy     (flash_rdy),
        .limit   (busy_limit),
        .finish  (wait_finish),
        .expired (wait_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            div_q       <= '0;
            spi_sck     <= 1'b0;
            spi_cs_n    <= 1'b1;
            done        <= 1'b0;
            err_range   <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            done        <= 1'b0;
            err_range   <= 1'b0;
            err_timeout <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (in_range) begin
                            div_q    <= div_half;
                            spi_cs_n <= 1'b0;
                            state    <= ST_SETUP;
                        end else begin
                            err_range <= 1'b1;
                        end
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        spi_sck <= 1'b1;
                        state   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (spi_sck) begin
                            spi_sck <= 1'b0;
                            if (sh_last) begin
                                state <= ST_HOLD;
                            end
                        end else begin
                            spi_sck <= 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        spi_cs_n <= 1'b1;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_expired) begin
                        err_timeout <= 1'b1;
                        state       <= ST_IDLE;
                    end else if (wait_finish) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign spi_sdo   = sh_sdo & ~spi_cs_n;
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker (
    input logic clk,
    input logic rst,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_sdo,
    input logic flash_rdy,
    input logic req_ready,
    input logic done,
    input logic err_range,
    input logic err_timeout
);
    assert_sck_idle_R4: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    assert_sdo_steady_R4: assert property (@(posedge clk) disable iff (rst)
        (spi_sck && $past(spi_sck)) |-> (spi_sdo == $past(spi_sdo)));

    assert_cs_rise_low_sck_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_cs_n) |-> !$past(spi_sck));

    assert_range_no_frame_R7: assert property (@(posedge clk) disable iff (rst)
        err_range |-> spi_cs_n);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_ready_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(flash_rdy));

    assert_busy_gate_R9: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> !req_ready);

    assert_timeout_excl_R10: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> !done);
endmodule

bind flash_cmd_seq flash_seq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n),
    .spi_sdo     (spi_sdo),
    .flash_rdy   (flash_rdy),
    .req_ready   (req_ready),
    .done        (done),
    .err_range   (err_range),
    .err_timeout (err_timeout)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cmd = '0;
    logic        req_buf = 1'b0;
    logic [13:0] req_page = '0;
    logic [7:0]  div_half = '0;
    logic [19:0] busy_limit = 20'd1000;
    logic        req_ready, done, err_range, err_timeout;
    logic        spi_sck, spi_cs_n, spi_sdo;
    logic        flash_rdy = 1'b1;

    int checks = 0;
    int errors = 0;

    // monitor and device model state
    int          cyc = 0;
    logic        cs_prev = 1'b1, sck_prev = 1'b0, sdo_prev = 1'b0;
    logic [31:0] cap = '0;
    int edges = 0, hi_len = 0, hp_bad = 0, unstable = 0, idle_bad = 0, hold_bad = 0;
    int gap = -1, fall_cyc = 0, frames = 0, cs_falls = 0;
    int done_count = 0, done_cyc = 0, rel_cyc = 0, cs_rise_cyc = 0;
    int range_cnt = 0, tmo_cnt = 0, tmo_cyc = 0;
    int exp_div = 0, busy_len = 10, left = 0;
    bit release_now = 1'b0;

    flash_cmd_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_buf(req_buf), .req_page(req_page), .div_half(div_half),
        .busy_limit(busy_limit), .req_ready(req_ready), .done(done),
        .err_range(err_range), .err_timeout(err_timeout), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_sdo(spi_sdo), .flash_rdy(flash_rdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-clock observer and behavioural flash device
    always @(negedge clk) begin
        if (!rst) begin
            if (cs_prev && !spi_cs_n) begin
                cap = '0; edges = 0; hp_bad = 0; unstable = 0; gap = -1;
                fall_cyc = cyc; cs_falls++;
            end
            if (!spi_cs_n) begin
                if (spi_sck && !sck_prev) begin
                    if (edges == 0) gap = cyc - fall_cyc;
                    cap = {cap[30:0], spi_sdo};
                    edges++;
                    hi_len = 1;
                end else if (spi_sck && sck_prev) begin
                    hi_len++;
                    if (spi_sdo != sdo_prev) unstable++;
                end
                if (!spi_sck && sck_prev && hi_len != exp_div + 1) hp_bad++;
            end
            if (spi_cs_n && spi_sck) idle_bad++;
            if (!cs_prev && spi_cs_n) begin
                frames++;
                if (sck_prev) hold_bad++;
            end
            if (done) begin done_count++; done_cyc = cyc; end
            if (err_range) range_cnt++;
            if (err_timeout) begin tmo_cnt++; tmo_cyc = cyc; end
            // device: busy from chip-select rise for busy_len samples
            if (spi_cs_n && !cs_prev) begin
                flash_rdy = 1'b0;
                left = busy_len;
                cs_rise_cyc = cyc;
            end else if (!flash_rdy) begin
                if (release_now || left <= 1) begin
                    flash_rdy = 1'b1;
                    rel_cyc = cyc;
                end else begin
                    left--;
                end
            end
            cs_prev = spi_cs_n; sck_prev = spi_sck; sdo_prev = spi_sdo;
        end
        cyc++;
    end

    function automatic logic [7:0] exp_op(input int cmd, input int b);
        if (cmd == 0) return b ? 8'h86 : 8'h83;
        if (cmd == 1) return b ? 8'h89 : 8'h88;
        if (cmd == 2) return 8'h81;
        return 8'h50;
    endfunction

    function automatic logic [23:0] exp_addr(input int cmd, input logic [12:0] pg);
        if (cmd == 3) return {1'b0, pg[12:3], 13'b0};
        return {1'b0, pg, 10'b0};
    endfunction

    task automatic run_cmd(input int cmd, input int b, input int page, input int div,
                           input int blen, input bit interfere);
        int frames0, done0, i;
        bit bad_ready, fin;
        busy_len = blen; exp_div = div;
        frames0 = frames; done0 = done_count;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 2'(cmd); req_buf = 1'(b);
        req_page = 14'(page); div_half = 8'(div);
        @(negedge clk);
        req_valid = 1'b0;
        bad_ready = 1'b0; fin = 1'b0; i = 0;
        while (!fin && i < 20000) begin
            if (done) fin = 1'b1;
            else begin
                if (req_ready) bad_ready = 1'b1;
                if (interfere && i == 40) begin
                    req_valid = 1'b1; req_cmd = 2'd2; req_page = 14'h0123;
                end
                if (interfere && i == 41) req_valid = 1'b0;
                @(negedge clk);
                i++;
            end
        end
        repeat (6) @(negedge clk);
        chk(cap[31:24] == exp_op(cmd, b), "R1 opcode", cap[31:24], exp_op(cmd, b));
        chk(cap[23:0] == exp_addr(cmd, 13'(page)), (cmd == 3) ? "R3 block address" : "R2 page address",
            cap[23:0], exp_addr(cmd, 13'(page)));
        chk(edges == 32, "R4 rising edges", edges, 32);
        chk(unstable == 0 && idle_bad == 0, "R4 mode-0 timing", unstable + idle_bad, 0);
        chk(gap >= 1 && hold_bad == 0, "R5 chip-select framing", gap, 1);
        chk(hp_bad == 0, "R6 half period", hp_bad, 0);
        chk(done_count == done0 + 1, "R8 done count", done_count - done0, 1);
        chk(done_cyc == rel_cyc + 1, "R8 done timing", done_cyc, rel_cyc + 1);
        chk(!bad_ready && frames == frames0 + 1, "R9 busy gate", frames - frames0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "R8 watchdog", 0, 1);
        report();
    end

    initial begin
        int f0, c0, d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(spi_cs_n && !spi_sck && !spi_sdo, "R11 bus idle", {spi_cs_n, spi_sck, spi_sdo}, 3'b100);
        chk(req_ready && !done && !err_range && !err_timeout, "R11 flags",
            {req_ready, done, err_range, err_timeout}, 4'b1000);

        run_cmd(0, 0, 13'h1ABC, 0, 20, 1'b0);
        run_cmd(0, 1, 13'h0001, 1, 15, 1'b0);
        run_cmd(1, 0, 13'h1FFF, 2, 12, 1'b1);
        run_cmd(1, 1, 13'h0AAA, 0, 30, 1'b0);
        run_cmd(2, 1, 13'h1555, 3, 10, 1'b0);
        run_cmd(3, 0, 13'h1FFF, 1, 25, 1'b0);
        run_cmd(3, 1, 13'h0C0F, 0, 10, 1'b0);

        // R7: page 8192 refused
        f0 = frames; c0 = cs_falls;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 2'd0; req_page = 14'd8192;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(range_cnt == 1, "R7 range pulse", range_cnt, 1);
        chk(frames == f0 && cs_falls == c0 && req_ready, "R7 no frame", cs_falls - c0, 0);

        // R10: device stays busy past the limit
        d0 = done_count; f0 = frames;
        busy_limit = 20'd40;
        busy_len = 100000; exp_div = 1;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = 2'd2; req_page = 14'h0042; div_half = 8'd1;
        @(negedge clk);
        req_valid = 1'b0;
        begin
            int k = 0;
            while (!err_timeout && k < 5000) begin @(negedge clk); k++; end
        end
        repeat (2) @(negedge clk);
        chk(tmo_cnt == 1, "R10 timeout pulse", tmo_cnt, 1);
        chk(tmo_cyc - cs_rise_cyc >= 40 && tmo_cyc - cs_rise_cyc <= 48, "R10 timeout window",
            tmo_cyc - cs_rise_cyc, 40);
        chk(done_count == d0 && frames == f0 + 1, "R10 no done", done_count - d0, 0);
        chk(req_ready, "R10 back to idle", req_ready, 1);
        release_now = 1'b1;
        repeat (4) @(negedge clk);
        release_now = 1'b0;
        chk(done_count == d0 && req_ready, "R10 late ready ignored", done_count - d0, 0);

        report();
    end
endmodule